// File: doc/BRIEF.md
# Codec Status Frame Transmitter

This block sits on the codec side of a five-wire audio controller link. On each new frame marker it takes a snapshot of the codec's state and shifts out one 256-bit return frame on the serial data line toward the controller. That state is the ready flag, a pending register-read result, the per-slot sample-request flags and up to eight 18-bit capture samples. The frame is a 16-bit tag slot followed by twelve 20-bit slots, sent MSB first.

The frame marker (`sync`) is sampled on the falling edge of the bit clock. The serial output changes only on rising edges. A read result is delivered in the frame after the one that carried the read command, so the surrounding logic presents it as a pending-read record. Slot 1 does two jobs. Its upper field echoes the register index, but only for reads. Its middle field carries the sample-request flags, gated by a variable-rate enable. The analog converters and the rate-conversion filters sit elsewhere.

Top module: `ac_sdin_tx`

## Requirements
- R1: Tag slot, with bit position 0 of the frame being tag bit 15: bit 15 = `codec_rdy`, bit 14 = slot 1 valid, bit 13 = slot 2 valid, bits 12 down to 5 = valid for capture slots 3 to 10 (`cap_vld[0]` to `cap_vld[7]`), bits 4 to 0 always 0.
- R2: When `rd_vld` is 1, slot 1 bits 18:12 carry `rd_idx`, slot 2 bits 19:4 carry `rd_data`, and tag bits 14 and 13 are 1.
- R3: When `rd_vld` is 0, slot 1 bits 18:12 and all of slot 2 are 0, and tag bits 14 and 13 are 0.
- R4: With `vra_en` = 1, slot 1 bits 11 down to 4 carry the request flags for slots 3 to 10 in that order. Each flag is the inverse of `smp_want[k]`, where k = slot - 3, so a 0 on the wire asks for a new sample in the next frame.
- R5: With `vra_en` = 0, slot 1 bits 11:4 are all 0.
- R6: Capture slot 3+k carries `cap_data[18k+17:18k]` in bits 19:2, MSB first, with bits 1:0 at 0 when `cap_vld[k]` is 1. When `cap_vld[k]` is 0, the whole slot is 0.
- R7: Slot 1 bits 19 and 3:0, slot 2 bits 3:0, and all of slots 11 and 12 are driven 0.
- R8: Tag bit 15 appears on the rising edge that follows the falling edge where `sync` is first sampled high. Each following bit appears on the next rising edge, and the output holds across falling edges.
- R9: While `rst` is high, and after it until the first frame starts, `sdata_in` is 0. Once a frame's 256 bits have been sent, the output stays 0.
- R10: A `sync` level that stays high starts only one frame. A new frame needs `sync` to be sampled low and then high again.
- R11: All frame contents are captured at the rising edge that sends bit 0. Input changes later in the frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | serial bit clock |
| rst | input | 1 | synchronous active-high reset |
| sync | input | 1 | frame marker from the controller |
| codec_rdy | input | 1 | codec is stable and ready |
| rd_vld | input | 1 | a register read result is pending |
| rd_idx | input | 7 | index of the register that was read |
| rd_data | input | 16 | value read from that register |
| vra_en | input | 1 | variable-rate mode enable |
| smp_want | input | 8 | per capture slot: codec wants a new sample (bit 0 = slot 3) |
| cap_data | input | 144 | eight 18-bit capture samples, slot 3 in bits 17:0 |
| cap_vld | input | 8 | per capture slot sample valid (bit 0 = slot 3) |
| sdata_in | output | 1 | serial return frame toward the controller |

## Verification
The frame builder is tried with vectors that set the ready flag high and low. They cross reads and writes, with index and data patterns of all ones, all zeros, a single top bit and mixed values. They also cross variable-rate mode on and off with sparse, full and empty request and capture-valid masks. This separates bit-order mistakes, such as reversed flags or swapped slot positions, from gating mistakes, such as an index echoed on writes or flags leaking when the mode is off. Directed runs cover the reset level, a `sync` held high, and a change of inputs partway through a frame. Every captured bit is also compared before and after the falling edge.

// File: rtl/ac_sdin_pkg.sv
package ac_sdin_pkg;

    localparam int TAG_W     = 16;
    localparam int SLOT_W    = 20;
    localparam int NUM_SLOTS = 12;
    localparam int FRAME_W   = TAG_W + NUM_SLOTS * SLOT_W;
    localparam int PCM_N     = 8;
    localparam int SMP_W     = 18;
    localparam int IDX_W     = 7;
    localparam int DAT_W     = 16;
    localparam int POS_W     = $clog2(FRAME_W);
    localparam int SMP_PAD   = SLOT_W - SMP_W;
    localparam int DAT_PAD   = SLOT_W - DAT_W;
    localparam int TAG_PAD   = TAG_W - 3 - PCM_N;
    localparam int TAIL_W    = FRAME_W - TAG_W - 2 * SLOT_W - PCM_N * SLOT_W;
    localparam int S1_PAD    = SLOT_W - 1 - IDX_W - PCM_N;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [DAT_W-1:0] data;
    } rd_rec_t;

    typedef struct packed {
        logic                   valid;
        logic [POS_W-1:0]       pos;
    } ser_state_t;

    // Frame bit position at which data slot s (1..NUM_SLOTS) begins.
    function automatic int slot_start(input int s);
        return TAG_W + (s - 1) * SLOT_W;
    endfunction

endpackage

// File: rtl/ac_sdin_sync_edge.sv
module ac_sdin_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic start_o
);
    logic sync_d;

    // Marker sampled on falling edges; start holds a full bit period.
    always_ff @(negedge clk) begin
        if (rst) begin
            sync_d  <= 1'b0;
            start_o <= 1'b0;
        end else begin
            sync_d  <= sync_i;
            start_o <= sync_i & ~sync_d;
        end
    end

    // R10: a held marker yields a single start
    a_r10_one_start: assert property (@(negedge clk) disable iff (rst)
        start_o |=> !start_o);

endmodule

// File: rtl/ac_sdin_frame_build.sv
module ac_sdin_frame_build
    import ac_sdin_pkg::*;
(
    input  logic                    ready_i,
    input  rd_rec_t                 rd_i,
    input  logic                    vra_i,
    input  logic [PCM_N-1:0]        want_i,
    input  logic [PCM_N*SMP_W-1:0]  cap_i,
    input  logic [PCM_N-1:0]        cap_vld_i,
    output logic [FRAME_W-1:0]      frame_o
);
    logic [TAG_W-1:0]        tag;
    logic [SLOT_W-1:0]       slot1;
    logic [SLOT_W-1:0]       slot2;
    logic [PCM_N-1:0]        req_field;
    logic [PCM_N-1:0]        vld_field;
    logic [PCM_N*SLOT_W-1:0] pcm_bus;

    // Slot order reverses into MSB-first fields: slot 3 lands highest.
    for (genvar g = 0; g < PCM_N; g++) begin : g_pcm
        logic [SMP_W-1:0] smp;
        assign smp                    = cap_i[g*SMP_W +: SMP_W];
        assign req_field[PCM_N-1-g]   = vra_i & ~want_i[g];
        assign vld_field[PCM_N-1-g]   = cap_vld_i[g];
        assign pcm_bus[(PCM_N-1-g)*SLOT_W +: SLOT_W] =
            cap_vld_i[g] ? {smp, {SMP_PAD{1'b0}}} : '0;
    end

    always_comb begin
        tag   = {ready_i, rd_i.vld, rd_i.vld, vld_field, {TAG_PAD{1'b0}}};
        slot1 = {1'b0, (rd_i.vld ? rd_i.idx : {IDX_W{1'b0}}), req_field,
                 {S1_PAD{1'b0}}};
        slot2 = rd_i.vld ? {rd_i.data, {DAT_PAD{1'b0}}} : '0;
        frame_o = {tag, slot1, slot2, pcm_bus, {TAIL_W{1'b0}}};
    end

endmodule

// File: rtl/ac_sdin_serializer.sv
module ac_sdin_serializer
    import ac_sdin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               sdata_o,
    output ser_state_t         st_o
);
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            sdata_o  <= 1'b0;
            st_o     <= '0;
        end else if (start_i) begin
            sdata_o   <= frame_i[FRAME_W-1];
            shreg     <= {frame_i[FRAME_W-2:0], 1'b0};
            st_o.valid <= 1'b1;
            st_o.pos   <= '0;
        end else if (st_o.valid) begin
            if (st_o.pos == POS_W'(FRAME_W - 1)) begin
                sdata_o    <= 1'b0;
                st_o.valid <= 1'b0;
            end else begin
                sdata_o  <= shreg[FRAME_W-1];
                shreg    <= {shreg[FRAME_W-2:0], 1'b0};
                st_o.pos <= st_o.pos + 1'b1;
            end
        end
    end

    // R9: line stays low outside a frame
    a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
        !st_o.valid |-> !sdata_o);

endmodule

// File: rtl/ac_sdin_tx.sv
module ac_sdin_tx
    import ac_sdin_pkg::*;
(
    input  logic                   bclk,
    input  logic                   rst,
    input  logic                   sync,
    input  logic                   codec_rdy,
    input  logic                   rd_vld,
    input  logic [6:0]             rd_idx,
    input  logic [15:0]            rd_data,
    input  logic                   vra_en,
    input  logic [7:0]             smp_want,
    input  logic [143:0]           cap_data,
    input  logic [7:0]             cap_vld,
    output logic                   sdata_in
);
    logic               start;
    rd_rec_t            rd_rec;
    logic [FRAME_W-1:0] frame;
    ser_state_t         ser_st;

    assign rd_rec = '{vld: rd_vld, idx: rd_idx, data: rd_data};

    ac_sdin_sync_edge u_edge (
        .clk     (bclk),
        .rst     (rst),
        .sync_i  (sync),
        .start_o (start)
    );

    ac_sdin_frame_build u_build (
        .ready_i   (codec_rdy),
        .rd_i      (rd_rec),
        .vra_i     (vra_en),
        .want_i    (smp_want),
        .cap_i     (cap_data),
        .cap_vld_i (cap_vld),
        .frame_o   (frame)
    );

    ac_sdin_serializer u_ser (
        .clk     (bclk),
        .rst     (rst),
        .start_i (start),
        .frame_i (frame),
        .sdata_o (sdata_in),
        .st_o    (ser_st)
    );

    // R8: first bit after the start edge is the ready flag
    a_r8_first_bit: assert property (@(posedge bclk) disable iff (rst)
        start |=> (sdata_in == $past(codec_rdy)));

    // R1: low five tag bits are zero on the wire
    a_r1_tag_pad: assert property (@(posedge bclk) disable iff (rst)
        (ser_st.valid && ser_st.pos >= POS_W'(TAG_W - 5) &&
         ser_st.pos <= POS_W'(TAG_W - 1)) |-> !sdata_in);

    // R7: slots 11 and 12 are zero on the wire
    a_r7_tail_zero: assert property (@(posedge bclk) disable iff (rst)
        (ser_st.valid && ser_st.pos >= POS_W'(slot_start(NUM_SLOTS - 1)))
        |-> !sdata_in);

    // R7: slot 1 top bit is zero on the wire
    a_r7_s1_top: assert property (@(posedge bclk) disable iff (rst)
        (ser_st.valid && ser_st.pos == POS_W'(slot_start(1))) |-> !sdata_in);

endmodule

// File: tb/ac_sdin_tx_bench.sv
module ac_sdin_tx_bench;

    localparam int CLK_P = 20;

    typedef struct packed {
        logic        rdy;
        logic        rv;
        logic [6:0]  idx;
        logic [15:0] dat;
        logic        vra;
        logic [7:0]  want;
        logic [7:0]  cv;
        logic [17:0] seed;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 7'h26, 16'hA5C3, 1'b1, 8'hA6, 8'hFF, 18'h2A5F1},
        '{1'b1, 1'b0, 7'h7F, 16'hFFFF, 1'b1, 8'h00, 8'h0F, 18'h3FFFF},
        '{1'b0, 1'b1, 7'h7F, 16'hFFFF, 1'b0, 8'hFF, 8'h00, 18'h00000},
        '{1'b1, 1'b1, 7'h00, 16'h0001, 1'b0, 8'h5A, 8'h81, 18'h20001},
        '{1'b1, 1'b0, 7'h11, 16'h1234, 1'b1, 8'hFF, 8'hF0, 18'h15555},
        '{1'b1, 1'b1, 7'h7C, 16'h8000, 1'b1, 8'h01, 8'h3C, 18'h3FFFF}
    };

    logic         bclk = 1'b0;
    logic         rst = 1'b1;
    logic         sync = 1'b0;
    logic         codec_rdy = 1'b0;
    logic         rd_vld = 1'b0;
    logic [6:0]   rd_idx = '0;
    logic [15:0]  rd_data = '0;
    logic         vra_en = 1'b0;
    logic [7:0]   smp_want = '0;
    logic [143:0] cap_data = '0;
    logic [7:0]   cap_vld = '0;
    logic         sdata_in;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) bclk = ~bclk;

    ac_sdin_tx u_ac_sdin_tx (
        .bclk(bclk), .rst(rst), .sync(sync), .codec_rdy(codec_rdy),
        .rd_vld(rd_vld), .rd_idx(rd_idx), .rd_data(rd_data),
        .vra_en(vra_en), .smp_want(smp_want), .cap_data(cap_data),
        .cap_vld(cap_vld), .sdata_in(sdata_in)
    );

    function automatic logic [17:0] smp_of(vec_t v, int k);
        return 18'(v.seed + 18'(k) * 18'h0B3D);
    endfunction

    task automatic apply(vec_t v);
        codec_rdy = v.rdy; rd_vld = v.rv; rd_idx = v.idx; rd_data = v.dat;
        vra_en = v.vra; smp_want = v.want; cap_vld = v.cv;
        for (int k = 0; k < 8; k++) cap_data[k*18 +: 18] = smp_of(v, k);
    endtask

    // Expected frame, index 255 - p holds frame bit position p.
    function automatic logic [255:0] exp_frame(vec_t v);
        logic [255:0] f = '0;
        f[255] = v.rdy;
        f[254] = v.rv;
        f[253] = v.rv;
        for (int k = 0; k < 8; k++) f[252-k] = v.cv[k];
        if (v.rv) f[238:232] = v.idx;
        for (int k = 0; k < 8; k++) f[231-k] = v.vra & ~v.want[k];
        if (v.rv) f[219:204] = v.dat;
        for (int k = 0; k < 8; k++)
            if (v.cv[k]) f[199-20*k -: 18] = smp_of(v, k);
        return f;
    endfunction

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic hold, input logic chg, input vec_t alt,
                             output logic [255:0] got);
        int held_bad = 0;
        @(posedge bclk); #1 sync = 1'b1;
        for (int p = 0; p < 256; p++) begin
            logic a, b;
            @(posedge bclk); #5 a = sdata_in; #10 b = sdata_in;
            got[255-p] = a;
            if (a !== b) held_bad++;
            if (p == 15 && !hold) sync = 1'b0;
            if (p == 3 && chg) apply(alt);
        end
        check("R8 output held across falling edge", 256'(held_bad), 256'(0));
    endtask

    task automatic check_frame(logic [255:0] g, logic [255:0] e);
        check("R8 first bit is ready flag", 256'(g[255]), 256'(e[255]));
        check("R1 tag slot", 256'(g[255:240]), 256'(e[255:240]));
        check("R2 R3 slot1 index echo", 256'(g[238:232]), 256'(e[238:232]));
        check("R4 R5 request flags", 256'(g[231:224]), 256'(e[231:224]));
        check("R2 R3 slot2 read data", 256'(g[219:200]), 256'(e[219:200]));
        check("R6 capture slots", 256'(g[199:40]), 256'(e[199:40]));
        check("R7 padding and slots 11-12",
              256'({g[239], g[223:220], g[203:200], g[39:0]}),
              256'({e[239], e[223:220], e[203:200], e[39:0]}));
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_P * 200000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        report();
        $finish;
    end

    initial begin
        logic [255:0] got;
        int low_bad;

        // R9: reset level
        low_bad = 0;
        apply(VECS[0]);
        for (int i = 0; i < 5; i++) begin
            @(posedge bclk); #5 if (sdata_in !== 1'b0) low_bad++;
        end
        @(posedge bclk); #1 rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(posedge bclk); #5 if (sdata_in !== 1'b0) low_bad++;
        end
        check("R9 output low in and after reset", 256'(low_bad), 256'(0));

        // Vector table
        for (int v = 0; v < NV; v++) begin
            apply(VECS[v]);
            run_frame(1'b0, 1'b0, VECS[v], got);
            check_frame(got, exp_frame(VECS[v]));
        end

        // R11: mid-frame input change has no effect
        apply(VECS[0]);
        run_frame(1'b0, 1'b1, VECS[2], got);
        check("R11 frame snapshot at start", got, exp_frame(VECS[0]));

        // R10 and R9: marker held high starts one frame only
        apply(VECS[5]);
        run_frame(1'b1, 1'b0, VECS[5], got);
        check("R10 held marker first frame", got, exp_frame(VECS[5]));
        low_bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(posedge bclk); #5 if (sdata_in !== 1'b0) low_bad++;
        end
        check("R10 R9 no restart while marker high", 256'(low_bad), 256'(0));
        #1 sync = 1'b0;
        @(posedge bclk);

        // New edge after low restarts framing
        apply(VECS[3]);
        run_frame(1'b0, 1'b0, VECS[3], got);
        check("R10 restart after marker low", got, exp_frame(VECS[3]));

        report();
        $finish;
    end

endmodule